// File: doc/BRIEF.md
# Two-Pass Image FFT Sequencer

This block orders the work of a two-dimensional FFT over a square N×N image of complex samples held in a frame memory. The image is transformed in two sweeps: first along every row, then along every column. In each sweep it takes a group of up to eight lines at a time. It copies the group from the frame memory into the working buffer of an external one-dimensional FFT engine and starts the engine. When the engine reports completion, it copies the group back out, normalising each word on the way.

The arithmetic engine and the data mover are outside the block. The engine is reached through a start/done handshake. The buffer is reached through load and unload strobes that carry a line index and a point index. The frame memory is a read port with one cycle of latency and a write port. Each sample is a pair of 32-bit fixed-point words, one real and one imaginary.

Top module: `fft2d_seq`

## Requirements
- R1: While reset is held and after it is released, the block is idle: busy_o, done_o, both frame-memory strobes, both buffer strobes and fft_start_o are all low until a start is accepted.
- R2: A start_i pulse seen while idle begins a transform. A start_i pulse seen while busy_o is high has no effect: no frame-memory, buffer or engine operation is repeated or added.
- R3: Every row group is written back before the first column read. In the row sweep a sample at line L, point P is at frame address L*N+P. In the column sweep it is at address P*N+L. Groups run in ascending order, and group g holds lines 8g to 8g+7.
- R4: To load a group, the block reads the frame memory line by line in ascending line order, and within each line point by point from 0 to N-1. Each read is followed exactly one cycle later by a buffer load strobe carrying the line index within the group (0..7), the point index, and the real and imaginary words returned by the memory.
- R5: One cycle after the last load strobe of a group, fft_start_o pulses for exactly one cycle. With it come fft_scale_o, which is 1 in the row sweep (scale to fixed point, then bit-reverse) and 0 in the column sweep (bit-reverse only), and fft_mask_o, whose bit l is 1 exactly when 8g+l < N.
- R6: The block waits for fft_done_i and ignores that input at any other time. It then unloads the group from the buffer in the same line/point order as the load. Each buffer read is followed one cycle later by a frame-memory write to the same address the load read from.
- R7: Each word written back is the buffer word arithmetically shifted right by log2(N), on both the real and the imaginary part, in both sweeps.
- R8: busy_o stays high from the cycle after an accepted start until the cycle of done_o, inclusive. done_o is a single-cycle pulse in the cycle directly after the final column write.
- R9: A frame-memory read never occurs in the same cycle as a frame-memory write or a buffer unload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a transform (accepted only while idle) |
| busy_o | output | 1 | Transform in progress |
| done_o | output | 1 | One-cycle completion pulse |
| mem_rd_o | output | 1 | Frame-memory read strobe |
| mem_rd_addr_o | output | 2*log2(N) | Frame-memory read address |
| mem_rd_re_i | input | 32 | Read data, real part, one cycle after the strobe |
| mem_rd_im_i | input | 32 | Read data, imaginary part |
| mem_wr_o | output | 1 | Frame-memory write strobe |
| mem_wr_addr_o | output | 2*log2(N) | Frame-memory write address |
| mem_wr_re_o | output | 32 | Write data, real part, normalised |
| mem_wr_im_o | output | 32 | Write data, imaginary part, normalised |
| buf_ld_o | output | 1 | Buffer load strobe |
| buf_ld_line_o | output | 3 | Line index within the group for the load |
| buf_ld_pt_o | output | log2(N) | Point index for the load |
| buf_ld_re_o | output | 32 | Load data, real part |
| buf_ld_im_o | output | 32 | Load data, imaginary part |
| buf_rd_o | output | 1 | Buffer unload strobe |
| buf_rd_line_o | output | 3 | Line index within the group for the unload |
| buf_rd_pt_o | output | log2(N) | Point index for the unload |
| buf_rd_re_i | input | 32 | Unload data, real part, one cycle after the strobe |
| buf_rd_im_i | input | 32 | Unload data, imaginary part |
| fft_start_o | output | 1 | Engine start pulse |
| fft_scale_o | output | 1 | 1: scale then bit-reverse; 0: bit-reverse only |
| fft_mask_o | output | 8 | Valid-line mask for the group |
| fft_done_i | input | 1 | Engine completion pulse |

## Verification
The hardest conditions to reach from the ports are stray control events arriving in the middle of a transform. These are a start_i pulse while busy, and an fft_done_i pulse during a load, when no engine run is pending. The bench injects both at fixed offsets after the accepted start. It then proves that they changed nothing: every strobe is popped from a queue of expected operations built from the address formulas, and the final frame contents are compared with a behavioural two-pass model. A second instance at N=4 exercises the partial group, where the valid-line mask is 0x0F.

// File: rtl/fft2d_seq_pkg.sv
package fft2d_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_LOAD, S_LFLUSH, S_FGO, S_FWAIT, S_STORE, S_SFLUSH, S_DONE
  } seq_state_e;
endpackage

// File: rtl/fft2d_walk.sv
module fft2d_walk #(
  parameter int LINES = 8,
  parameter int NPTS  = 16,
  parameter int LW    = 3,
  parameter int PW    = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          step_i,
  output logic [LW-1:0] line_o,
  output logic [PW-1:0] pt_o,
  output logic          last_o
);
  localparam logic [LW-1:0] LINE_MAX = LW'(LINES - 1);
  localparam logic [PW-1:0] PT_MAX   = PW'(NPTS - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      line_o <= '0;
      pt_o   <= '0;
    end else if (clr_i) begin
      line_o <= '0;
      pt_o   <= '0;
    end else if (step_i) begin
      if (pt_o == PT_MAX) begin
        pt_o   <= '0;
        line_o <= (line_o == LINE_MAX) ? '0 : line_o + 1'b1;
      end else begin
        pt_o <= pt_o + 1'b1;
      end
    end
  end

  assign last_o = (line_o == LINE_MAX) && (pt_o == PT_MAX);
endmodule

// File: rtl/fft2d_addr.sv
module fft2d_addr #(
  parameter int LGN = 4,
  parameter int GW  = 1,
  parameter int LW  = 3
) (
  input  logic             col_i,
  input  logic [GW-1:0]    grp_i,
  input  logic [LW-1:0]    line_i,
  input  logic [LGN-1:0]   pt_i,
  output logic [2*LGN-1:0] addr_o
);
  logic [LGN-1:0] lidx;
  // group*8 + line, truncated to the image height
  assign lidx   = LGN'({grp_i, line_i});
  assign addr_o = col_i ? {pt_i, lidx} : {lidx, pt_i};
endmodule

// File: rtl/fft2d_norm.sv
module fft2d_norm #(
  parameter int DW = 32,
  parameter int SH = 4
) (
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] d_o
);
  assign d_o = $signed(d_i) >>> SH;
endmodule

// File: rtl/fft2d_seq.sv
module fft2d_seq
  import fft2d_seq_pkg::*;
#(
  parameter int N   = 16,
  parameter int DW  = 32,
  parameter int GRP = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      start_i,
  output logic                      busy_o,
  output logic                      done_o,
  output logic                      mem_rd_o,
  output logic [2*$clog2(N)-1:0]    mem_rd_addr_o,
  input  logic [DW-1:0]             mem_rd_re_i,
  input  logic [DW-1:0]             mem_rd_im_i,
  output logic                      mem_wr_o,
  output logic [2*$clog2(N)-1:0]    mem_wr_addr_o,
  output logic [DW-1:0]             mem_wr_re_o,
  output logic [DW-1:0]             mem_wr_im_o,
  output logic                      buf_ld_o,
  output logic [$clog2(GRP)-1:0]    buf_ld_line_o,
  output logic [$clog2(N)-1:0]      buf_ld_pt_o,
  output logic [DW-1:0]             buf_ld_re_o,
  output logic [DW-1:0]             buf_ld_im_o,
  output logic                      buf_rd_o,
  output logic [$clog2(GRP)-1:0]    buf_rd_line_o,
  output logic [$clog2(N)-1:0]      buf_rd_pt_o,
  input  logic [DW-1:0]             buf_rd_re_i,
  input  logic [DW-1:0]             buf_rd_im_i,
  output logic                      fft_start_o,
  output logic                      fft_scale_o,
  output logic [GRP-1:0]            fft_mask_o,
  input  logic                      fft_done_i
);
  localparam int LGN   = $clog2(N);
  localparam int AW    = 2 * LGN;
  localparam int LW    = $clog2(GRP);
  localparam int NGRP  = (N + GRP - 1) / GRP;
  localparam int GW    = (NGRP > 1) ? $clog2(NGRP) : 1;
  localparam int LINES = (N < GRP) ? N : GRP;

  seq_state_e     state_q;
  logic           pass_q;   // 0: rows, 1: columns
  logic [GW-1:0]  grp_q;
  logic [LW-1:0]  walk_line;
  logic [LGN-1:0] walk_pt;
  logic           walk_last;
  logic [AW-1:0]  cur_addr;
  logic           last_grp;

  logic           ld_v_q;
  logic [LW-1:0]  ld_line_q;
  logic [LGN-1:0] ld_pt_q;
  logic           st_v_q;
  logic [AW-1:0]  st_addr_q;

  fft2d_walk #(.LINES(LINES), .NPTS(N), .LW(LW), .PW(LGN)) u_walk (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (state_q == S_IDLE),
    .step_i ((state_q == S_LOAD) || (state_q == S_STORE)),
    .line_o (walk_line),
    .pt_o   (walk_pt),
    .last_o (walk_last)
  );

  fft2d_addr #(.LGN(LGN), .GW(GW), .LW(LW)) u_addr (
    .col_i  (pass_q),
    .grp_i  (grp_q),
    .line_i (walk_line),
    .pt_i   (walk_pt),
    .addr_o (cur_addr)
  );

  fft2d_norm #(.DW(DW), .SH(LGN)) u_norm_re (.d_i(buf_rd_re_i), .d_o(mem_wr_re_o));
  fft2d_norm #(.DW(DW), .SH(LGN)) u_norm_im (.d_i(buf_rd_im_i), .d_o(mem_wr_im_o));

  assign last_grp = (grp_q == GW'(NGRP - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      pass_q  <= 1'b0;
      grp_q   <= '0;
    end else begin
      case (state_q)
        S_IDLE:   if (start_i) begin
                    pass_q  <= 1'b0;
                    grp_q   <= '0;
                    state_q <= S_LOAD;
                  end
        S_LOAD:   if (walk_last) state_q <= S_LFLUSH;
        S_LFLUSH: state_q <= S_FGO;
        S_FGO:    state_q <= S_FWAIT;
        S_FWAIT:  if (fft_done_i) state_q <= S_STORE;
        S_STORE:  if (walk_last) state_q <= S_SFLUSH;
        S_SFLUSH: begin
                    if (last_grp) begin
                      grp_q <= '0;
                      if (pass_q) state_q <= S_DONE;
                      else begin
                        pass_q  <= 1'b1;
                        state_q <= S_LOAD;
                      end
                    end else begin
                      grp_q   <= grp_q + 1'b1;
                      state_q <= S_LOAD;
                    end
                  end
        S_DONE:   state_q <= S_IDLE;
        default:  state_q <= S_IDLE;
      endcase
    end
  end

  // one-cycle data return on both memories
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ld_v_q    <= 1'b0;
      ld_line_q <= '0;
      ld_pt_q   <= '0;
      st_v_q    <= 1'b0;
      st_addr_q <= '0;
    end else begin
      ld_v_q    <= (state_q == S_LOAD);
      ld_line_q <= walk_line;
      ld_pt_q   <= walk_pt;
      st_v_q    <= (state_q == S_STORE);
      st_addr_q <= cur_addr;
    end
  end

  assign busy_o        = (state_q != S_IDLE);
  assign done_o        = (state_q == S_DONE);
  assign mem_rd_o      = (state_q == S_LOAD);
  assign mem_rd_addr_o = cur_addr;
  assign buf_ld_o      = ld_v_q;
  assign buf_ld_line_o = ld_line_q;
  assign buf_ld_pt_o   = ld_pt_q;
  assign buf_ld_re_o   = mem_rd_re_i;
  assign buf_ld_im_o   = mem_rd_im_i;
  assign buf_rd_o      = (state_q == S_STORE);
  assign buf_rd_line_o = walk_line;
  assign buf_rd_pt_o   = walk_pt;
  assign mem_wr_o      = st_v_q;
  assign mem_wr_addr_o = st_addr_q;
  assign fft_start_o   = (state_q == S_FGO);
  assign fft_scale_o   = !pass_q;

  for (genvar gi = 0; gi < GRP; gi++) begin : g_mask
    assign fft_mask_o[gi] = ((int'(grp_q) * GRP + gi) < N);
  end
endmodule

// File: rtl/fft2d_seq_chk.sv
module fft2d_seq_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic busy_o,
  input logic done_o,
  input logic mem_rd_o,
  input logic mem_wr_o,
  input logic buf_ld_o,
  input logic buf_rd_o,
  input logic fft_start_o
);
  assert_idle_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !(mem_rd_o || mem_wr_o || buf_ld_o || buf_rd_o || fft_start_o || done_o));

  assert_start_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> busy_o);

  assert_ld_after_rd_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> buf_ld_o);

  assert_start_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fft_start_o |=> !fft_start_o);

  assert_wr_after_unload_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_rd_o |=> mem_wr_o);

  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o));

  assert_busy_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);

  assert_no_overlap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |-> !(mem_wr_o || buf_rd_o));
endmodule

bind fft2d_seq fft2d_seq_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .mem_rd_o    (mem_rd_o),
  .mem_wr_o    (mem_wr_o),
  .buf_ld_o    (buf_ld_o),
  .buf_rd_o    (buf_rd_o),
  .fft_start_o (fft_start_o)
);

// File: tb/tb_fft2d_seq.sv
module tb_fft2d_seq_env #(
  parameter int N     = 16,
  parameter int CLK_P = 10
) (
  input logic clk,
  input logic rst_n,
  input logic go
);
  localparam int LGN   = $clog2(N);
  localparam int AW    = 2 * LGN;
  localparam int NGRP  = (N + 7) / 8;

  logic          start_i, busy_o, done_o;
  logic          mem_rd_o, mem_wr_o, buf_ld_o, buf_rd_o, fft_start_o, fft_scale_o, fft_done_i;
  logic [AW-1:0] mem_rd_addr_o, mem_wr_addr_o;
  logic [31:0]   mem_rd_re_i, mem_rd_im_i, mem_wr_re_o, mem_wr_im_o;
  logic [31:0]   buf_ld_re_o, buf_ld_im_o, buf_rd_re_i, buf_rd_im_i;
  logic [2:0]    buf_ld_line_o, buf_rd_line_o;
  logic [LGN-1:0] buf_ld_pt_o, buf_rd_pt_o;
  logic [7:0]    fft_mask_o;

  fft2d_seq #(.N(N)) dut (.clk_i(clk), .rst_ni(rst_n), .*);

  int frame_re [N*N];
  int frame_im [N*N];
  int exp_re [N*N];
  int exp_im [N*N];
  int bre [8][N];
  int bim [8][N];
  int q_rd[$], q_wr[$], q_ld[$], q_ft[$];
  int n_cmp = 0, n_bad = 0, n_done = 0;
  bit fin = 0, run = 0, exp_busy = 0;
  int cyc = 0, last_wr = -10, spur_at = -1, cnt = 0, f_scale = 0, f_mask = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s N=%0d cyc=%0d actual=%0d expected=%0d", req, N, cyc, act, exp);
    end
  endtask

  function automatic int br(input int k);
    int r = 0;
    for (int b = 0; b < LGN; b++) if (k[b]) r |= 1 << (LGN - 1 - b);
    return r;
  endfunction

  function automatic int mask_of(input int g);
    int m = 0;
    for (int l = 0; l < 8; l++) if (g * 8 + l < N) m |= 1 << l;
    return m;
  endfunction

  // reference: engine bit-reverses, adds 1000 to real when scaling; block shifts on write-back
  task automatic build_ref();
    int tr [N];
    int ti [N];
    for (int i = 0; i < N*N; i++) begin exp_re[i] = frame_re[i]; exp_im[i] = frame_im[i]; end
    for (int p = 0; p < 2; p++)
      for (int ln = 0; ln < N; ln++) begin
        for (int k = 0; k < N; k++) begin
          int a = (p == 0) ? ln * N + br(k) : br(k) * N + ln;
          tr[k] = exp_re[a] + ((p == 0) ? 1000 : 0);
          ti[k] = exp_im[a];
        end
        for (int k = 0; k < N; k++) begin
          int a = (p == 0) ? ln * N + k : k * N + ln;
          exp_re[a] = tr[k] >>> LGN;
          exp_im[a] = ti[k] >>> LGN;
        end
      end
    for (int p = 0; p < 2; p++)
      for (int g = 0; g < NGRP; g++) begin
        for (int l = 0; l < 8; l++) begin
          if (g * 8 + l >= N) continue;
          for (int k = 0; k < N; k++) begin
            int ln = g * 8 + l;
            int a = (p == 0) ? ln * N + k : k * N + ln;
            q_rd.push_back(a);
            q_wr.push_back(a);
            q_ld.push_back(l * N + k);
          end
        end
        q_ft.push_back(((p == 0) ? 256 : 0) + mask_of(g));
      end
  endtask

  always @(negedge clk) begin
    if (rst_n && run) begin
      int v;
      cyc++;
      if (start_i && !exp_busy) exp_busy = 1;
      chk(busy_o == exp_busy, "R8 busy", busy_o, exp_busy);
      if (mem_rd_o) begin
        v = (q_rd.size() > 0) ? q_rd.pop_front() : -1;
        chk(int'(mem_rd_addr_o) == v, "R3 read address", mem_rd_addr_o, v);
        chk(!mem_wr_o && !buf_rd_o, "R9 overlap", mem_wr_o, 0);
      end
      if (buf_ld_o) begin
        v = (q_ld.size() > 0) ? q_ld.pop_front() : -1;
        chk(int'(buf_ld_line_o) * N + int'(buf_ld_pt_o) == v, "R4 load index",
            int'(buf_ld_line_o) * N + int'(buf_ld_pt_o), v);
        chk(buf_ld_re_o == mem_rd_re_i && buf_ld_im_o == mem_rd_im_i, "R4 load data",
            buf_ld_re_o, mem_rd_re_i);
        bre[buf_ld_line_o][buf_ld_pt_o] = buf_ld_re_o;
        bim[buf_ld_line_o][buf_ld_pt_o] = buf_ld_im_o;
      end
      if (mem_wr_o) begin
        v = (q_wr.size() > 0) ? q_wr.pop_front() : -1;
        chk(int'(mem_wr_addr_o) == v, "R6 write address", mem_wr_addr_o, v);
        frame_re[mem_wr_addr_o] = mem_wr_re_o;
        frame_im[mem_wr_addr_o] = mem_wr_im_o;
        last_wr = cyc;
      end
      if (fft_start_o) begin
        v = (q_ft.size() > 0) ? q_ft.pop_front() : -1;
        chk(int'(fft_scale_o) * 256 + int'(fft_mask_o) == v, "R5 start scale/mask",
            int'(fft_scale_o) * 256 + int'(fft_mask_o), v);
        chk(q_ld.size() % (N * ((N < 8) ? N : 8)) == 0, "R5 start after group load",
            q_ld.size(), 0);
        f_scale = fft_scale_o;
        f_mask  = fft_mask_o;
        cnt     = 3 + (q_ft.size() % 3);
      end
      if (done_o) begin
        n_done++;
        chk(q_wr.size() == 0 && cyc == last_wr + 1, "R8 done timing", cyc, last_wr + 1);
        exp_busy = 0;
      end
      // models, updated after sampling
      if (mem_rd_o) begin
        mem_rd_re_i = frame_re[mem_rd_addr_o];
        mem_rd_im_i = frame_im[mem_rd_addr_o];
      end
      if (buf_rd_o) begin
        buf_rd_re_i = bre[buf_rd_line_o][buf_rd_pt_o];
        buf_rd_im_i = bim[buf_rd_line_o][buf_rd_pt_o];
      end
      fft_done_i = 0;
      if (cnt > 0) begin
        cnt--;
        if (cnt == 0) begin
          for (int l = 0; l < 8; l++) begin
            int tr [N];
            int ti [N];
            if (!f_mask[l]) continue;
            for (int k = 0; k < N; k++) begin
              tr[k] = bre[l][br(k)] + (f_scale ? 1000 : 0);
              ti[k] = bim[l][br(k)];
            end
            for (int k = 0; k < N; k++) begin bre[l][k] = tr[k]; bim[l][k] = ti[k]; end
          end
          fft_done_i = 1;
        end
      end
      if (cyc == spur_at) fft_done_i = 1;
    end
  end

  initial begin
    start_i = 0; fft_done_i = 0;
    mem_rd_re_i = '0; mem_rd_im_i = '0; buf_rd_re_i = '0; buf_rd_im_i = '0;
    for (int i = 0; i < N*N; i++) begin
      frame_re[i] = (i * 37 - 300) * 1013;
      frame_im[i] = 5000 - i * 711;
    end
    wait (go);
    @(negedge clk);
    // R1: quiet after reset
    chk(!busy_o && !done_o, "R1 idle flags", busy_o, 0);
    chk(!(mem_rd_o || mem_wr_o || buf_ld_o || buf_rd_o || fft_start_o), "R1 strobes",
        mem_rd_o, 0);
    build_ref();
    run = 1;
    #(CLK_P / 4) start_i = 1;
    @(negedge clk); #(CLK_P / 4) start_i = 0;
    spur_at = cyc + 4;     // stray engine completion during the first load
    repeat (20) @(negedge clk);
    #(CLK_P / 4) start_i = 1;   // R2: start while busy
    @(negedge clk); #(CLK_P / 4) start_i = 0;
    wait (n_done == 1);
    repeat (6) @(negedge clk);
    chk(n_done == 1 && !busy_o, "R2 single run", n_done, 1);
    chk(q_rd.size() + q_wr.size() + q_ld.size() + q_ft.size() == 0, "R2 all ops issued once",
        q_rd.size() + q_wr.size(), 0);
    for (int i = 0; i < N*N; i++) begin
      chk(frame_re[i] == exp_re[i], "R7 result real", frame_re[i], exp_re[i]);
      chk(frame_im[i] == exp_im[i], "R7 result imag", frame_im[i], exp_im[i]);
    end
    fin = 1;
  end
endmodule

module tb_fft2d_seq;
  localparam int CLK_P = 10;
  logic clk = 0, rst_n = 0, go = 0;
  int wd = 0, wd_fail = 0;

  always #(CLK_P / 2) clk = ~clk;

  tb_fft2d_seq_env #(.N(16), .CLK_P(CLK_P)) env_big   (.clk(clk), .rst_n(rst_n), .go(go));
  tb_fft2d_seq_env #(.N(4),  .CLK_P(CLK_P)) env_small (.clk(clk), .rst_n(rst_n), .go(go));

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);
    go = 1;
    while (!(env_big.fin && env_small.fin) && wd < 100000) begin
      @(negedge clk);
      wd++;
    end
    if (wd >= 100000) begin
      wd_fail = 1;
      $display("FAIL watchdog R8 actual=%0d expected=%0d", wd, 0);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***",
             env_big.n_cmp + env_small.n_cmp + wd_fail,
             env_big.n_bad + env_small.n_bad + wd_fail);
    $finish;
  end
endmodule